// File: doc/BRIEF.md
# I2C Hung-Bus Recovery Sequencer

This block frees an I2C bus that a target device has left stuck, typically with SDA held low after a transfer was cut short. A single-cycle `recover_i` strobe starts a recovery run. For the whole run the block holds the neighbouring byte-level controller in reset. It first lets go of both lines and waits a settle window. It then repeatedly checks whether the bus is idle, and if it is not, it pulls SCL low for a fixed time and lets it go again. Each extra clock lets the stuck target shift out the rest of its byte and release SDA.

The bus counts as idle only when both SCL and SDA read high. The check is made before every pulse, so the run ends at the first check that finds an idle bus. The number of pulses is capped. A run that reaches the cap with the bus still busy ends with `fail`; any other run ends with `done`. On completion the controller reset drops, and the same cycle brings a one-cycle request to re-initialise the controller. The block never pulls SDA low.

All timing comes from the `CLK_HZ` parameter together with nanosecond parameters for the low pulse and the settle window. The SCL and SDA inputs pass through a parameterised synchroniser before the checks use them. These pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_unstick`

## Requirements
- R1: After reset, `scl_drive_low`, `sda_drive_low`, `ctrl_reset`, `reinit_req`, `done` and `fail` are all 0.
- R2: In the clock cycle after an accepted `recover_i` strobe, `ctrl_reset` is 1. It stays 1 until the run ends and is 1 during every SCL pulse.
- R3: `sda_drive_low` is 0 in every cycle, whatever the bus does.
- R4: If both lines read high at the first check after the initial settle window, the run ends with `done` = 1 and no SCL pulse.
- R5: Each SCL pulse holds `scl_drive_low` at 1 for exactly LOW_CYC = ceil(CLK_HZ*LOW_NS/1e9) consecutive cycles. This is 50 cycles for CLK_HZ = 5 MHz and LOW_NS = 10000.
- R6: After each pulse, SCL is released for at least SETTLE_CYC + 1 cycles before the next pulse, where SETTLE_CYC = max(ceil(CLK_HZ*SETTLE_NS/1e9), SYNC_STAGES+1). This is 10 cycles for 5 MHz and 2000 ns.
- R7: The bus is idle only when SCL and SDA both read high. The run ends at the first check that sees this, so a target that needs k pulses (k <= MAX_PULSES) gets exactly k, and the run ends with `done` = 1 and `fail` = 0.
- R8: At most MAX_PULSES pulses are issued per run. If the bus is still busy at the check after the last allowed pulse, the run ends with `fail` = 1 and `done` = 0.
- R9: The run ends with `reinit_req` high for exactly one cycle, in the same cycle that `ctrl_reset` falls. `done`/`fail` keep their values until the next accepted strobe, and the two are never 1 together.
- R10: A `recover_i` strobe during a run is ignored. The pulse count and the single `reinit_req` of that run are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recover_i | input | 1 | Start strobe, accepted only when idle |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low (always 0) |
| ctrl_reset | output | 1 | Holds the byte controller in reset during a run |
| reinit_req | output | 1 | One-cycle request to re-initialise the controller |
| done | output | 1 | Last run ended with the bus idle |
| fail | output | 1 | Last run hit the pulse cap with the bus still busy |

## Verification
The assertions watch, on every cycle, the invariants that hold regardless of bus behaviour: the exact width of each SCL pulse, that any pulse falls inside the controller reset, the pulse cap, the one-cycle re-init request and where it lands, and that the two result flags are exclusive. Only the bench scenarios can show how the run responds to a modelled target. These cover a target that needs no pulses, one that needs exactly k pulses up to the cap, one that needs one more than the cap, and SCL held low by another device. They show that the pulse count, the choice between `done` and `fail`, and the handling of a stray strobe match the expected values.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RELEASE = 3'd1,
    ST_CHECK   = 3'd2,
    ST_LOW     = 3'd3,
    ST_SETTLE  = 3'd4
  } unstick_state_e;

  // Cycles covering a duration in ns, rounded up, never below one.
  function automatic int ns_to_cycles(input longint clk_hz, input longint dur_ns);
    longint c;
    c = (clk_hz * dur_ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '1;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic             expired
);
  logic [WIDTH-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (load)           remain <= load_val;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/unstick_pulse_count.sv
module unstick_pulse_count #(
  parameter int LIMIT = 100,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic at_limit
);
  logic [CW-1:0] issued;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   issued <= '0;
    else if (clear)               issued <= '0;
    else if (bump && !at_limit)   issued <= issued + 1'b1;
  end

  assign at_limit = (issued == CW'(LIMIT));
endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
  import unstick_pkg::*;
#(
  parameter int LOW_CYC    = 1000,
  parameter int SETTLE_CYC = 500,
  parameter int TW         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bus_idle,
  input  logic          tmr_expired,
  input  logic          cap_reached,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          cnt_clear,
  output logic          cnt_bump,
  output logic          pull_scl,
  output logic          hold_ctrl,
  output logic          reinit_pulse,
  output logic          ok_flag,
  output logic          bad_flag
);
  unstick_state_e state, state_nx;
  logic finish_ok, finish_bad;

  always_comb begin
    state_nx   = state;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    cnt_clear  = 1'b0;
    cnt_bump   = 1'b0;
    finish_ok  = 1'b0;
    finish_bad = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          state_nx  = ST_RELEASE;
          tmr_load  = 1'b1;
          tmr_val   = TW'(SETTLE_CYC - 1);
          cnt_clear = 1'b1;
        end
      end
      ST_RELEASE, ST_SETTLE: begin
        if (tmr_expired) state_nx = ST_CHECK;
      end
      ST_CHECK: begin
        if (bus_idle) begin
          finish_ok = 1'b1;
          state_nx  = ST_IDLE;
        end else if (cap_reached) begin
          finish_bad = 1'b1;
          state_nx   = ST_IDLE;
        end else begin
          state_nx = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = TW'(LOW_CYC - 1);
          cnt_bump = 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_expired) begin
          state_nx = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = TW'(SETTLE_CYC - 1);
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      ok_flag      <= 1'b0;
      bad_flag     <= 1'b0;
      reinit_pulse <= 1'b0;
    end else begin
      state        <= state_nx;
      reinit_pulse <= finish_ok | finish_bad;
      if (state == ST_IDLE && start) begin
        ok_flag  <= 1'b0;
        bad_flag <= 1'b0;
      end else begin
        if (finish_ok)  ok_flag  <= 1'b1;
        if (finish_bad) bad_flag <= 1'b1;
      end
    end
  end

  assign pull_scl  = (state == ST_LOW);
  assign hold_ctrl = (state != ST_IDLE);
endmodule

// File: rtl/bus_unstick.sv
module bus_unstick
  import unstick_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int LOW_NS      = 10_000,
  parameter int SETTLE_NS   = 5_000,
  parameter int MAX_PULSES  = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_i,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_drive_low,
  output logic sda_drive_low,
  output logic ctrl_reset,
  output logic reinit_req,
  output logic done,
  output logic fail
);
  localparam int LOW_CYC    = ns_to_cycles(longint'(CLK_HZ), longint'(LOW_NS));
  localparam int SETTLE_CYC = max_int(ns_to_cycles(longint'(CLK_HZ), longint'(SETTLE_NS)),
                                      SYNC_STAGES + 1);
  localparam int TW         = $clog2(max_int(LOW_CYC, SETTLE_CYC) + 1);

  logic [1:0]    lines_sync;
  logic          bus_idle;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          cnt_clear, cnt_bump, cap_reached;

  unstick_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({scl_in, sda_in}),
    .q_sync  (lines_sync)
  );

  assign bus_idle = lines_sync[1] & lines_sync[0];

  unstick_timer #(.WIDTH(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  unstick_pulse_count #(.LIMIT(MAX_PULSES)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .bump     (cnt_bump),
    .at_limit (cap_reached)
  );

  unstick_fsm #(.LOW_CYC(LOW_CYC), .SETTLE_CYC(SETTLE_CYC), .TW(TW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (recover_i),
    .bus_idle     (bus_idle),
    .tmr_expired  (tmr_expired),
    .cap_reached  (cap_reached),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .cnt_clear    (cnt_clear),
    .cnt_bump     (cnt_bump),
    .pull_scl     (scl_drive_low),
    .hold_ctrl    (ctrl_reset),
    .reinit_pulse (reinit_req),
    .ok_flag      (done),
    .bad_flag     (fail)
  );

  // SDA is only ever released by this block (R3).
  assign sda_drive_low = 1'b0;
endmodule

// File: rtl/unstick_checker.sv
module unstick_checker #(
  parameter int LOW_CYC    = 1000,
  parameter int MAX_PULSES = 100
) (
  input logic clk,
  input logic rst_n,
  input logic scl_drive_low,
  input logic ctrl_reset,
  input logic reinit_req,
  input logic done,
  input logic fail
);
  localparam int LW = $clog2(LOW_CYC + 2);
  localparam int PW = $clog2(MAX_PULSES + 2);

  logic [LW-1:0] low_run;
  logic [PW-1:0] run_pulses;
  logic          scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run    <= '0;
      run_pulses <= '0;
      scl_q      <= 1'b0;
    end else begin
      scl_q <= scl_drive_low;
      if (scl_drive_low) begin
        if (low_run != '1) low_run <= low_run + 1'b1;
      end else begin
        low_run <= '0;
      end
      if (!ctrl_reset)                        run_pulses <= '0;
      else if (scl_drive_low && !scl_q &&
               run_pulses != '1)              run_pulses <= run_pulses + 1'b1;
    end
  end

  assert_pulse_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> ctrl_reset);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && !scl_drive_low) |-> (low_run == LW'(LOW_CYC)));

  assert_pulse_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> (low_run < LW'(LOW_CYC)));

  assert_pulse_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_pulses <= PW'(MAX_PULSES));

  assert_reinit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_req |=> !reinit_req);

  assert_reinit_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reinit_req) |-> $fell(ctrl_reset));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
endmodule

bind bus_unstick unstick_checker #(.LOW_CYC(LOW_CYC), .MAX_PULSES(MAX_PULSES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_drive_low (scl_drive_low),
  .ctrl_reset    (ctrl_reset),
  .reinit_req    (reinit_req),
  .done          (done),
  .fail          (fail)
);

// File: tb/tb_bus_unstick.sv
module tb_bus_unstick;
  localparam int CLK_PERIOD = 10;
  localparam int P_CLK_HZ   = 5_000_000;
  localparam int P_LOW_NS   = 10_000;
  localparam int P_SET_NS   = 2_000;
  localparam int P_MAX      = 100;
  // Expected from the requirements: ceil(5e6*10e-6)=50, max(ceil(5e6*2e-6),3)=10.
  localparam int EXP_LOW    = 50;
  localparam int EXP_SETTLE = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic recover_i = 1'b0;
  logic scl_stuck = 1'b0;
  logic slave_hold = 1'b0;
  logic scl_drive_low, sda_drive_low, ctrl_reset, reinit_req, done, fail;
  wire  scl_line = !(scl_drive_low || scl_stuck);
  wire  sda_line = !(sda_drive_low || slave_hold);

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_unstick #(
    .CLK_HZ(P_CLK_HZ), .LOW_NS(P_LOW_NS), .SETTLE_NS(P_SET_NS),
    .MAX_PULSES(P_MAX), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .recover_i(recover_i),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .ctrl_reset(ctrl_reset), .reinit_req(reinit_req),
    .done(done), .fail(fail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int need, input bit stuck);
    if (stuck || need > P_MAX) return P_MAX;
    return need;
  endfunction

  function automatic bit exp_fail(input int need, input bit stuck);
    return stuck || (need > P_MAX);
  endfunction

  // need: SCL pulses the modelled target needs before releasing SDA.
  task automatic run_case(input int need, input bit stuck, input int stray_at);
    int  pulses = 0, cyc = 0, width = 0, gap = 0;
    int  bad_width = 0, bad_gap = 0, sda_hits = 0, unreset = 0, reinits = 0;
    bit  prev_low = 1'b0, seen_fall = 1'b0, timed_out = 1'b0;
    @(negedge clk);
    scl_stuck  = stuck;
    slave_hold = (need > 0);
    recover_i  = 1'b1;
    @(negedge clk);
    recover_i = 1'b0;
    chk(ctrl_reset == 1'b1, "R2", "ctrl_reset after strobe", ctrl_reset, 1);
    forever begin
      cyc++;
      recover_i = (cyc == stray_at);
      if (sda_drive_low) sda_hits++;
      if (scl_drive_low && !ctrl_reset) unreset++;
      if (scl_drive_low && !prev_low) begin
        pulses++;
        if (seen_fall && gap < EXP_SETTLE + 1) bad_gap++;
        width = 0;
        if (pulses >= need) slave_hold = 1'b0;
      end
      if (scl_drive_low) width++;
      if (!scl_drive_low && prev_low) begin
        if (width != EXP_LOW) bad_width++;
        seen_fall = 1'b1;
        gap = 0;
      end
      if (!scl_drive_low) gap++;
      prev_low = scl_drive_low;
      if (reinit_req) begin
        reinits++;
        break;
      end
      if (cyc > 20000) begin
        timed_out = 1'b1;
        break;
      end
      @(negedge clk);
    end
    recover_i = 1'b0;
    chk(!timed_out, "R9", "run finished", cyc, 0);
    chk(ctrl_reset == 1'b0, "R9", "ctrl_reset low with reinit", ctrl_reset, 0);
    chk(pulses == exp_pulses(need, stuck), "R7/R8 pulses", "count", pulses, exp_pulses(need, stuck));
    chk(fail == exp_fail(need, stuck), "R8", "fail flag", fail, exp_fail(need, stuck));
    chk(done == !exp_fail(need, stuck), "R7", "done flag", done, !exp_fail(need, stuck));
    chk(bad_width == 0, "R5", "wrong-width pulses", bad_width, 0);
    chk(bad_gap == 0, "R6", "short release gaps", bad_gap, 0);
    chk(sda_hits == 0, "R3", "cycles SDA driven", sda_hits, 0);
    chk(unreset == 0, "R2", "pulses outside reset", unreset, 0);
    if (need == 0 && !stuck)
      chk(pulses == 0, "R4", "pulses on idle bus", pulses, 0);
    repeat (3) begin
      @(negedge clk);
      if (reinit_req) reinits++;
    end
    chk(reinits == 1, "R9 R10", "reinit pulses", reinits, 1);
    chk(done == !exp_fail(need, stuck) && fail == exp_fail(need, stuck),
        "R9", "flags held", {done, fail}, {!exp_fail(need, stuck), exp_fail(need, stuck)});
    chk(ctrl_reset == 1'b0 && scl_drive_low == 1'b0, "R9", "idle after run",
        {ctrl_reset, scl_drive_low}, 0);
    scl_stuck  = 1'b0;
    slave_hold = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({scl_drive_low, sda_drive_low, ctrl_reset, reinit_req, done, fail} == 6'b0,
        "R1", "outputs in reset",
        {scl_drive_low, sda_drive_low, ctrl_reset, reinit_req, done, fail}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({scl_drive_low, sda_drive_low, ctrl_reset, reinit_req, done, fail} == 6'b0,
        "R1", "outputs after reset",
        {scl_drive_low, sda_drive_low, ctrl_reset, reinit_req, done, fail}, 0);

    run_case(0, 1'b0, 0);      // R4 idle bus
    run_case(1, 1'b0, 0);      // R7 single pulse
    run_case(P_MAX, 1'b0, 0);  // R7 boundary: last allowed pulse frees the bus
    run_case(P_MAX + 1, 1'b0, 0); // R8 one beyond the cap
    run_case(3, 1'b1, 0);      // R8 SCL held low elsewhere
    run_case(5, 1'b0, 120);    // R10 stray strobe mid-run
    for (int i = 0; i < 8; i++) begin
      int n;
      int s;
      n = int'($urandom_range(0, 60));
      s = (($urandom_range(0, 1)) == 1) ? int'($urandom_range(5, 200)) : 0;
      run_case(n, 1'b0, s);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule